// File: doc/BRIEF.md
# Hint-Guided Adaptive Fetch Throttle

This block decides, one cycle at a time, whether the fetch stage should be held for a cycle. It combines two sources. The first is a small estimated-parallelism hint that arrives with decoded instructions and is held in a register. The second is a decode/issue surplus: how many more instructions were decoded than issued in the previous cycle.

When the held hint is no larger than the surplus, the instructions already waiting can cover the demand of the next cycle. The block then raises a stall request toward the fetch clock gate for that one cycle. The throttling threshold is not fixed. It follows the surplus from cycle to cycle and is capped at a configurable ceiling, 5 by default.

A surplus of zero or below never throttles. A hint above the ceiling never throttles. The count inputs come from the decode and issue stages every cycle. The hint input is sampled only on cycles where its valid strobe is high.

Top module: `fetch_throttle`

## Requirements
- R1: After reset the held hint is the all-ones code (7 for a 3-bit hint), so no stall is requested before the first valid hint, whatever the counts are.
- R2: The decoded and issued counts presented in cycle k are registered, and they decide `stall_req` in cycle k+1 only. Each cycle's request is a fresh one-cycle decision.
- R3: The surplus is the registered decoded count minus the registered issued count, computed signed. A negative result counts as zero.
- R4: `stall_req` is 1 exactly when the surplus is above zero and the held hint is less than or equal to min(surplus, THR_MAX).
- R5: With a surplus of zero, `stall_req` is 0 for every hint value, including hint 0.
- R6: The effective threshold never exceeds THR_MAX (5). A held hint of 6 or 7 never causes a stall, even at the largest surplus of 8.
- R7: The hint register loads `hint_val` at a clock edge where `hint_vld` is 1. It holds its value while `hint_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_cnt | input | 4 | Instructions decoded this cycle, 0 to ISSUE_W |
| iss_cnt | input | 4 | Instructions issued this cycle, 0 to ISSUE_W |
| hint_vld | input | 1 | Strobe: `hint_val` carries a new estimate |
| hint_val | input | 3 | Estimated-parallelism hint code |
| stall_req | output | 1 | Hold fetch for this one cycle |

## Verification
The bench builds the block with its defaults: ISSUE_W=8, HINT_W=3 and THR_MAX=5. These values put both the ceiling and the count extremes within reach. Hints 6 and 7 lie above the ceiling of 5, and a surplus of 8 lies above it too, so clamping from either side can be exercised. Counts from 0 to 8 also reach a surplus of -8 and a surplus of +8.

A behavioural model with integer state predicts `stall_req` every cycle. Directed sequences cover reset, the hint equal to the surplus, the hint one above the surplus, hint hold, and the one-cycle release. Random traffic then covers the rest.

// File: rtl/fthr_pkg.sv
package fthr_pkg;

    localparam int DEF_ISSUE_W = 8;
    localparam int DEF_HINT_W  = 3;
    localparam int DEF_THR_MAX = 5;

    typedef enum logic [1:0] {
        WHY_IDLE   = 2'd0,
        WHY_CAPPED = 2'd1,
        WHY_ABOVE  = 2'd2,
        WHY_GATE   = 2'd3
    } gate_why_e;

    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fthr_occupancy.sv
module fthr_occupancy #(
    parameter int ISSUE_W = fthr_pkg::DEF_ISSUE_W,
    localparam int CNT_W  = fthr_pkg::cnt_bits(ISSUE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] dec_cnt,
    input  logic [CNT_W-1:0] iss_cnt,
    output logic [CNT_W-1:0] surplus
);
    logic [CNT_W-1:0]      dec_q;
    logic [CNT_W-1:0]      iss_q;
    logic signed [CNT_W:0] diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
            iss_q <= '0;
        end else begin
            dec_q <= dec_cnt;
            iss_q <= iss_cnt;
        end
    end

    always_comb begin
        diff = $signed({1'b0, dec_q}) - $signed({1'b0, iss_q});
        if (diff[CNT_W])
            surplus = '0;
        else
            surplus = diff[CNT_W-1:0];
    end

    AST_NEG_SURPLUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(iss_cnt) > $past(dec_cnt)) |-> (surplus == '0)); // R3

    AST_DEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (dec_cnt <= CNT_W'(ISSUE_W)) && (iss_cnt <= CNT_W'(ISSUE_W))); // R2
endmodule

// File: rtl/fthr_hint_latch.sv
module fthr_hint_latch #(
    parameter int HINT_W = fthr_pkg::DEF_HINT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hint_vld,
    input  logic [HINT_W-1:0] hint_val,
    output logic [HINT_W-1:0] hint_q
);
    always_ff @(posedge clk) begin
        if (rst)
            hint_q <= '1;
        else if (hint_vld)
            hint_q <= hint_val;
    end

    AST_HINT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hint_vld |=> $stable(hint_q)); // R7
endmodule

// File: rtl/fthr_compare.sv
module fthr_compare
    import fthr_pkg::*;
#(
    parameter int ISSUE_W = DEF_ISSUE_W,
    parameter int HINT_W  = DEF_HINT_W,
    parameter int THR_MAX = DEF_THR_MAX,
    localparam int CNT_W  = cnt_bits(ISSUE_W),
    localparam int CMP_W  = (CNT_W > HINT_W) ? CNT_W : HINT_W
) (
    input  logic [HINT_W-1:0] hint_q,
    input  logic [CNT_W-1:0]  surplus,
    output gate_why_e         why
);
    logic [CMP_W-1:0] thr;
    logic [CMP_W-1:0] hint_x;

    generate
        if (THR_MAX < ISSUE_W) begin : g_capped
            always_comb begin
                if (CMP_W'(surplus) > CMP_W'(THR_MAX))
                    thr = CMP_W'(THR_MAX);
                else
                    thr = CMP_W'(surplus);
            end
        end else begin : g_plain
            always_comb thr = CMP_W'(surplus);
        end
    endgenerate

    always_comb begin
        hint_x = CMP_W'(hint_q);
        if (surplus == '0)
            why = WHY_IDLE;
        else if (hint_x > CMP_W'(THR_MAX))
            why = WHY_CAPPED;
        else if (hint_x > thr)
            why = WHY_ABOVE;
        else
            why = WHY_GATE;
    end
endmodule

// File: rtl/fetch_throttle.sv
module fetch_throttle
    import fthr_pkg::*;
#(
    parameter int ISSUE_W = DEF_ISSUE_W,
    parameter int HINT_W  = DEF_HINT_W,
    parameter int THR_MAX = DEF_THR_MAX,
    localparam int CNT_W  = cnt_bits(ISSUE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  dec_cnt,
    input  logic [CNT_W-1:0]  iss_cnt,
    input  logic              hint_vld,
    input  logic [HINT_W-1:0] hint_val,
    output logic              stall_req
);
    logic [CNT_W-1:0]  surplus;
    logic [HINT_W-1:0] hint_q;
    gate_why_e         why;

    fthr_occupancy #(.ISSUE_W(ISSUE_W)) u_occ (
        .clk     (clk),
        .rst     (rst),
        .dec_cnt (dec_cnt),
        .iss_cnt (iss_cnt),
        .surplus (surplus)
    );

    fthr_hint_latch #(.HINT_W(HINT_W)) u_hint (
        .clk      (clk),
        .rst      (rst),
        .hint_vld (hint_vld),
        .hint_val (hint_val),
        .hint_q   (hint_q)
    );

    fthr_compare #(.ISSUE_W(ISSUE_W), .HINT_W(HINT_W), .THR_MAX(THR_MAX)) u_cmp (
        .hint_q  (hint_q),
        .surplus (surplus),
        .why     (why)
    );

    assign stall_req = (why == WHY_GATE);

    AST_NO_STALL_ZERO_SURPLUS: assert property (@(posedge clk) disable iff (rst)
        ($past(dec_cnt) <= $past(iss_cnt)) |-> !stall_req); // R5

    AST_CAP_HIGH_HINT: assert property (@(posedge clk) disable iff (rst)
        ($past(hint_vld) && ($past(hint_val) > HINT_W'(THR_MAX))) |-> !stall_req); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !stall_req); // R1
endmodule

// File: tb/fetch_throttle_bench.sv
module fetch_throttle_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] dec_cnt = '0;
    logic [3:0] iss_cnt = '0;
    logic       hint_vld = 1'b0;
    logic [2:0] hint_val = '0;
    logic       stall_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_dec, m_iss, m_hint;

    always #(PERIOD/2) clk = ~clk;

    fetch_throttle u_fetch_throttle (
        .clk(clk), .rst(rst), .dec_cnt(dec_cnt), .iss_cnt(iss_cnt),
        .hint_vld(hint_vld), .hint_val(hint_val), .stall_req(stall_req)
    );

    // drive at a negedge, model the edge, compare at the following negedge
    task automatic cyc(input int d, input int i, input bit v, input int h, input string tag);
        int s;
        int cap;
        bit exp;
        string t;
        dec_cnt  = 4'(d);
        iss_cnt  = 4'(i);
        hint_vld = v;
        hint_val = 3'(h);
        @(posedge clk);
        m_dec = d;
        m_iss = i;
        if (v) m_hint = h;
        @(negedge clk);
        s   = m_dec - m_iss;
        t   = tag;
        if (t == "") t = (s < 0) ? "R3" : (s == 0) ? "R5" : (m_hint > 5) ? "R6" : "R4";
        if (s < 0) s = 0;
        cap = (s > 5) ? 5 : s;
        exp = (s > 0) && (m_hint <= cap);
        checks++;
        if (stall_req !== exp) begin
            fails++;
            $display("FAIL %s: stall_req=%0b expected=%0b (dec=%0d iss=%0d hint=%0d)",
                     t, stall_req, exp, m_dec, m_iss, m_hint);
        end
    endtask

    initial begin
        m_dec = 0; m_iss = 0; m_hint = 7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: no hint loaded yet, large surplus
        cyc(8, 0, 0, 0, "R1");
        cyc(8, 0, 0, 0, "R1");
        // R4: hint equal to surplus gates, one above does not
        cyc(5, 2, 1, 3, "R4");
        cyc(5, 2, 1, 4, "R4");
        cyc(4, 0, 1, 1, "R4");
        // R5: zero surplus with hint 0
        cyc(3, 3, 1, 0, "R5");
        cyc(0, 0, 0, 0, "R5");
        // R3: negative surplus clamps to zero
        cyc(1, 6, 1, 0, "R3");
        cyc(0, 8, 0, 0, "R3");
        cyc(2, 1, 1, 1, "R3");
        // R6: ceiling at 5
        cyc(8, 0, 1, 5, "R6");
        cyc(8, 0, 1, 6, "R6");
        cyc(8, 0, 1, 7, "R6");
        cyc(7, 1, 0, 0, "R6");
        // R7: load 2, then strobe low with a high code on the bus
        cyc(4, 0, 1, 2, "R7");
        cyc(4, 0, 0, 7, "R7");
        cyc(2, 0, 0, 7, "R7");
        cyc(1, 0, 0, 7, "R7");
        // R2: one surplus cycle followed by a balanced one
        cyc(6, 0, 1, 1, "R2");
        cyc(0, 0, 0, 1, "R2");
        cyc(6, 0, 0, 1, "R2");
        cyc(3, 3, 0, 1, "R2");
        for (int n = 0; n < 2000; n++)
            cyc($urandom_range(0, 8), $urandom_range(0, 8), 1'($urandom_range(0, 1)),
                $urandom_range(0, 7), "");
        // R1: reset mid-run restores the all-ones hint
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_dec = 0; m_iss = 0; m_hint = 7;
        cyc(8, 0, 0, 0, "R1");
        cyc(8, 1, 0, 0, "R1");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule